// File: doc/BRIEF.md
# Phase-Accumulator Square-Wave Synthesizer

The block is a numerically controlled oscillator. On every clock it adds a frequency control word to a wide phase register and wraps modulo 2^ACC_W. The top bit of that register is a square wave, and its frequency is fcw / 2^ACC_W of the clock rate. Because the phase register can be 32 bits or wider, adjacent settings can sit only a few hertz apart at typical clock rates.

The design aims for a short adder path. The control word passes through a dedicated register that feeds the adder directly. A synchronous clear is applied by forcing both adder operands to zero, so no multiplexer sits between the carry chain and the phase register. The control word is narrower than the phase register and is zero-extended. The full phase word is also brought out so that neighbouring logic can use it.

Top module: `nco_clkgen`

## Requirements
- R1: While rst_ni is low, phase_o and clk_o are zero. The reset acts at once, without waiting for a clock edge.
- R2: At each rising edge with clr_i low, phase_o becomes its previous value plus the registered control word, zero-extended to ACC_W bits.
- R3: A value on fcw_i that is sampled at edge k is first added at edge k+1.
- R4: clk_o always equals bit ACC_W-1 of phase_o.
- R5: A rising edge with clr_i high leaves phase_o at zero. The control word is still captured on that edge, so accumulation resumes with it on the next edge.
- R6: The addition wraps modulo 2^ACC_W, and no carry is kept.
- R7: Starting from phase zero with a constant word W, clk_o shows exactly W rising transitions over 2^ACC_W clocks, and phase_o is back at zero at the end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous phase clear |
| fcw_i | input | FCW_W | Frequency control word |
| phase_o | output | ACC_W | Phase register value |
| clk_o | output | 1 | Generated square wave (phase MSB) |

## Verification
The assertions check on every cycle that the reset value holds, that the control-word register follows its input with a one-cycle delay, that each unclear step adds the registered word, and that a clear empties the phase register. Only the bench scenarios can show the end-to-end effects. These are the one-cycle latency seen at the ports, wrap-around near full scale, and the number of output periods over a full 2^ACC_W window, which the bench counts for a small and a maximal word.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int unsigned NCO_ACC_W = 33;
  localparam int unsigned NCO_FCW_W = 31;
endpackage

// File: rtl/nco_fcw_reg.sv
module nco_fcw_reg #(
  parameter int unsigned ACC_W = nco_pkg::NCO_ACC_W,
  parameter int unsigned FCW_W = nco_pkg::NCO_FCW_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [FCW_W-1:0] fcw_i,
  output logic [ACC_W-1:0] inc_o
);
  localparam int unsigned PAD_W = ACC_W - FCW_W;

  logic [FCW_W-1:0] fcw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fcw_q <= '0;
    else         fcw_q <= fcw_i;
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign inc_o = {{PAD_W{1'b0}}, fcw_q};
    end else begin : g_nopad
      assign inc_o = fcw_q;
    end
  endgenerate

  // one-cycle pipeline of the control word
  assert_fcw_pipe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> inc_o[FCW_W-1:0] == $past(fcw_i));
endmodule

// File: rtl/nco_opnd_gate.sv
module nco_opnd_gate #(
  parameter int unsigned ACC_W = nco_pkg::NCO_ACC_W
) (
  input  logic             clr_i,
  input  logic [ACC_W-1:0] acc_i,
  input  logic [ACC_W-1:0] inc_i,
  output logic [ACC_W-1:0] opa_o,
  output logic [ACC_W-1:0] opb_o
);
  // clear is folded into the operands, ahead of the carry chain
  logic [ACC_W-1:0] keep;
  assign keep  = {ACC_W{~clr_i}};
  assign opa_o = acc_i & keep;
  assign opb_o = inc_i & keep;
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int unsigned ACC_W = nco_pkg::NCO_ACC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [ACC_W-1:0] opa_i,
  input  logic [ACC_W-1:0] opb_i,
  output logic [ACC_W-1:0] acc_o
);
  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= opa_i + opb_i;
  end

  assign acc_o = acc_q;

  assert_reset_zero_R1: assert property (@(posedge clk_i)
    !rst_ni |-> acc_q == '0);

  assert_clear_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> acc_q == '0);
endmodule

// File: rtl/nco_clkgen.sv
module nco_clkgen #(
  parameter int unsigned ACC_W = nco_pkg::NCO_ACC_W,
  parameter int unsigned FCW_W = nco_pkg::NCO_FCW_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [FCW_W-1:0] fcw_i,
  output logic [ACC_W-1:0] phase_o,
  output logic             clk_o
);
  logic [ACC_W-1:0] inc;
  logic [ACC_W-1:0] opa;
  logic [ACC_W-1:0] opb;
  logic [ACC_W-1:0] acc;

  nco_fcw_reg #(.ACC_W(ACC_W), .FCW_W(FCW_W)) i_fcw_reg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .fcw_i (fcw_i),
    .inc_o (inc)
  );

  nco_opnd_gate #(.ACC_W(ACC_W)) i_opnd_gate (
    .clr_i(clr_i),
    .acc_i(acc),
    .inc_i(inc),
    .opa_o(opa),
    .opb_o(opb)
  );

  nco_phase_acc #(.ACC_W(ACC_W)) i_phase_acc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr_i),
    .opa_i (opa),
    .opb_i (opb),
    .acc_o (acc)
  );

  assign phase_o = acc;
  assign clk_o   = acc[ACC_W-1];

  // modulo step across modules (covers R6 wrap)
  assert_phase_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> phase_o == ACC_W'($past(phase_o) + $past(inc)));
endmodule

// File: tb/test_nco_clkgen.sv
`timescale 1ns/1ps
module test_nco_clkgen;
  localparam int unsigned ACC_W = 12;
  localparam int unsigned FCW_W = 10;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             clr_i = 1'b0;
  logic [FCW_W-1:0] fcw_i = '0;
  logic [ACC_W-1:0] phase_o;
  logic             clk_o;

  int checks = 0;
  int fails  = 0;

  logic [ACC_W-1:0] exp_q[$];
  string            tag_q[$];
  logic [ACC_W-1:0] m_acc  = '0;
  logic [FCW_W-1:0] m_fcwq = '0;

  always #2.5 clk = ~clk;

  nco_clkgen #(.ACC_W(ACC_W), .FCW_W(FCW_W)) i_nco_clkgen (
    .clk_i(clk), .rst_ni(rst_ni), .clr_i(clr_i), .fcw_i(fcw_i),
    .phase_o(phase_o), .clk_o(clk_o)
  );

  task automatic check(input string req, input logic [ACC_W-1:0] act,
                       input logic [ACC_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: one clock per call, pushes the expected phase after that edge
  task automatic drive(input logic [FCW_W-1:0] w, input logic clr, input string tag);
    @(negedge clk);
    fcw_i = w;
    clr_i = clr;
    m_acc  = clr ? '0 : ACC_W'(m_acc + {{(ACC_W-FCW_W){1'b0}}, m_fcwq});
    m_fcwq = w;
    exp_q.push_back(m_acc);
    tag_q.push_back(tag);
  endtask

  // monitor: compares just after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [ACC_W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, phase_o, e);
        check("R4", {{(ACC_W-1){1'b0}}, clk_o}, {{(ACC_W-1){1'b0}}, e[ACC_W-1]});
      end
    end
  end

  task automatic count_periods(input logic [FCW_W-1:0] w);
    int rises;
    logic prev;
    @(negedge clk);
    fcw_i = w;
    clr_i = 1'b1;
    @(negedge clk);
    clr_i = 1'b0;
    check("R7", phase_o, '0);
    prev  = clk_o;
    rises = 0;
    for (int i = 0; i < (1 << ACC_W); i++) begin
      @(posedge clk);
      #1;
      if (clk_o && !prev) rises++;
      prev = clk_o;
    end
    check("R7", ACC_W'(rises), ACC_W'(w));
    check("R7", phase_o, '0);
    m_acc  = phase_o;
    m_fcwq = w;
  endtask

  initial begin
    #3;
    check("R1", phase_o, '0);
    check("R1", {{(ACC_W-1){1'b0}}, clk_o}, '0);
    @(negedge clk);
    rst_ni = 1'b1;
    m_acc  = '0;
    m_fcwq = '0;

    // R2: plain stepping with small words
    drive(10'd1, 1'b0, "R2");
    for (int i = 0; i < 4; i++) drive(10'd1, 1'b0, "R2");
    // R3: change of word shows up one edge later
    drive(10'd100, 1'b0, "R3");
    drive(10'd100, 1'b0, "R3");
    drive(10'd7, 1'b0, "R3");
    drive(10'd7, 1'b0, "R3");
    // R6: large word wraps past 2^ACC_W
    for (int i = 0; i < 12; i++) drive(10'd1023, 1'b0, "R6");
    // R5: clear, word captured during clear is used next
    drive(10'd300, 1'b1, "R5");
    drive(10'd300, 1'b0, "R5");
    drive(10'd300, 1'b0, "R5");
    drive(10'd5, 1'b1, "R5");
    drive(10'd5, 1'b1, "R5");
    drive(10'd5, 1'b0, "R5");
    @(negedge clk);
    @(negedge clk);

    count_periods(10'd5);
    count_periods(10'd1023);

    // R1: reset acts without a clock edge
    drive(10'd200, 1'b0, "R2");
    drive(10'd200, 1'b0, "R2");
    @(negedge clk);
    #1;
    rst_ni = 1'b0;
    #0.5;
    check("R1", phase_o, '0);
    check("R1", {{(ACC_W-1){1'b0}}, clk_o}, '0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule